// File: doc/BRIEF.md
# Triggered Pulse Generator with Holdoff

This block is a synchronous state machine. A trigger input starts one output pulse of fixed width. When the pulse ends, the output is held low for a fixed holdoff interval. During the pulse and the holdoff the trigger has no effect. A parent design uses it to turn a trigger of any length into a clean pulse with a bounded repetition rate.

The machine has five states: an idle state, a load state and a countdown state for the high phase, and a load state and a countdown state for the low phase. Each load state presets a private down-counter. The matching countdown state runs until that counter is about to reach zero. A parameter sets the state-register encoding to binary, one-hot or Gray. A second parameter chooses whether the output is decoded from the current state or taken from a register fed by the next state. Both output choices have the same cycle timing at the port. The default pulse width is 6 cycles and the default holdoff is 10 cycles. Both are parameters.

Top module: `trig_pulse_gen`

## Requirements
- R1: A synchronous reset puts the machine in idle with `pulse_o` low. The first edge after reset that sees `trig_i` high starts a pulse of the full width.
- R2: In idle, a clock edge that samples `trig_i` high makes `pulse_o` go high in the cycle right after that edge.
- R3: In idle, while `trig_i` is sampled low, the machine stays idle and `pulse_o` stays low.
- R4: Each pulse keeps `pulse_o` high for exactly HIGH_CYCLES consecutive cycles (default 6).
- R5: After each pulse, `pulse_o` stays low for at least HOLD_CYCLES cycles (default 10). The trigger is ignored during that time.
- R6: If `trig_i` is held high, consecutive rising edges of `pulse_o` are exactly HIGH_CYCLES + HOLD_CYCLES + 1 cycles apart (17 by default). The single cycle spent in idle is the one in which the held trigger is sampled.
- R7: Any change on `trig_i` while the pulse is high does not lengthen it, shorten it or restart it.
- R8: STATE_ENC = 0 (binary), 1 (one-hot) and 2 (Gray), each combined with Q_REGISTERED = 0 (decoded from state) or 1 (registered), give the same `pulse_o` sequence for the same `trig_i` sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger request, sampled on each rising edge |
| pulse_o | output | 1 | Output pulse |

## Verification
The hardest condition to reach from the ports is a trigger arriving on the exact edge the holdoff ends. A trigger held high through a whole pulse and its holdoff reaches it every time. The bench then measures the rise-to-rise spacing. A trigger toggled on every cycle hits every phase of the counters. An LFSR-driven trigger and a reset asserted in the middle of a pulse, with the trigger high, cover the remaining orderings. Three instances with different encodings and output modes are compared on every cycle against the same behavioural model.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [2:0] {
        PG_IDLE    = 3'd0,
        PG_HI_LOAD = 3'd1,
        PG_HI_RUN  = 3'd2,
        PG_LO_LOAD = 3'd3,
        PG_LO_RUN  = 3'd4
    } pg_state_e;

    localparam int PG_NUM_STATES  = 5;
    localparam int PG_STATE_BITS  = 3;

    localparam int PG_ENC_BINARY  = 0;
    localparam int PG_ENC_ONEHOT  = 1;
    localparam int PG_ENC_GRAY    = 2;

    function automatic logic pg_is_high(pg_state_e s);
        return (s == PG_HI_LOAD) || (s == PG_HI_RUN);
    endfunction

    function automatic int pg_cnt_width(int a, int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m) + 1;
    endfunction

endpackage

// File: rtl/pg_phase_counter.sv
module pg_phase_counter import pg_pkg::*; #(
    parameter int CNT_W    = 4,
    parameter int LOAD_VAL = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (load_i) begin
            count_o <= CNT_W'(LOAD_VAL);
        end else if (dec_i && (count_o != '0)) begin
            count_o <= count_o - 1'b1;
        end
    end

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm import pg_pkg::*; #(
    parameter int STATE_ENC    = PG_ENC_BINARY,
    parameter bit Q_REGISTERED = 1'b0,
    parameter int CNT_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    output pg_state_e        state_o,
    output logic             hi_load_o,
    output logic             hi_dec_o,
    output logic             lo_load_o,
    output logic             lo_dec_o,
    output logic             pulse_o
);

    localparam int SW = (STATE_ENC == PG_ENC_ONEHOT) ? PG_NUM_STATES : PG_STATE_BITS;

    function automatic logic [SW-1:0] encode(pg_state_e s);
        logic [SW-1:0] code;
        if (STATE_ENC == PG_ENC_ONEHOT) begin
            code = SW'(1) << s;
        end else if (STATE_ENC == PG_ENC_GRAY) begin
            code = SW'(s ^ (s >> 1));
        end else begin
            code = SW'(s);
        end
        return code;
    endfunction

    function automatic pg_state_e decode(logic [SW-1:0] code);
        pg_state_e r;
        r = PG_IDLE;
        for (int i = 0; i < PG_NUM_STATES; i++) begin
            if (encode(pg_state_e'(i)) == code) begin
                r = pg_state_e'(i);
            end
        end
        return r;
    endfunction

    logic [SW-1:0] state_q;
    pg_state_e     cur;
    pg_state_e     nxt;

    always_comb begin
        cur = decode(state_q);
    end

    always_comb begin
        nxt = cur;
        case (cur)
            PG_IDLE:    if (trig_i) nxt = PG_HI_LOAD;
            PG_HI_LOAD: nxt = PG_HI_RUN;
            PG_HI_RUN:  if (hi_cnt_i <= CNT_W'(1)) nxt = PG_LO_LOAD;
            PG_LO_LOAD: nxt = PG_LO_RUN;
            PG_LO_RUN:  if (lo_cnt_i <= CNT_W'(1)) nxt = PG_IDLE;
            default:    nxt = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= encode(PG_IDLE);
        end else begin
            state_q <= encode(nxt);
        end
    end

    assign state_o   = cur;
    assign hi_load_o = (cur == PG_HI_LOAD);
    assign hi_dec_o  = (cur == PG_HI_RUN);
    assign lo_load_o = (cur == PG_LO_LOAD);
    assign lo_dec_o  = (cur == PG_LO_RUN);

    generate
        if (Q_REGISTERED) begin : g_q_reg
            logic q_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_r <= 1'b0;
                end else begin
                    q_r <= pg_is_high(nxt);
                end
            end
            assign pulse_o = q_r;
        end else begin : g_q_dec
            assign pulse_o = pg_is_high(cur);
        end
    endgenerate

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen import pg_pkg::*; #(
    parameter int HIGH_CYCLES  = 6,
    parameter int HOLD_CYCLES  = 10,
    parameter int STATE_ENC    = PG_ENC_BINARY,
    parameter bit Q_REGISTERED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int CNT_W = pg_cnt_width(HIGH_CYCLES, HOLD_CYCLES);

    pg_state_e        cur_state;
    logic             hi_load, hi_dec, lo_load, lo_dec;
    logic [CNT_W-1:0] hi_cnt, lo_cnt;

    pg_fsm #(
        .STATE_ENC    (STATE_ENC),
        .Q_REGISTERED (Q_REGISTERED),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .hi_cnt_i  (hi_cnt),
        .lo_cnt_i  (lo_cnt),
        .state_o   (cur_state),
        .hi_load_o (hi_load),
        .hi_dec_o  (hi_dec),
        .lo_load_o (lo_load),
        .lo_dec_o  (lo_dec),
        .pulse_o   (pulse_o)
    );

    pg_phase_counter #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (HIGH_CYCLES - 1)
    ) u_hi_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (hi_load),
        .dec_i   (hi_dec),
        .count_o (hi_cnt)
    );

    pg_phase_counter #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (HOLD_CYCLES - 1)
    ) u_lo_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (lo_load),
        .dec_i   (lo_dec),
        .count_o (lo_cnt)
    );

endmodule

// File: rtl/pg_checker.sv
module pg_checker import pg_pkg::*; #(
    parameter int HIGH_CYCLES = 6,
    parameter int HOLD_CYCLES = 10
) (
    input logic      clk,
    input logic      rst,
    input logic      trig_i,
    input logic      pulse_o,
    input pg_state_e state_i
);

    string state_name;
    always_comb begin
        case (state_i)
            PG_IDLE:    state_name = "IDLE";
            PG_HI_LOAD: state_name = "HI_LOAD";
            PG_HI_RUN:  state_name = "HI_RUN";
            PG_LO_LOAD: state_name = "LO_LOAD";
            PG_LO_RUN:  state_name = "LO_RUN";
            default:    state_name = "ILLEGAL";
        endcase
    end

    int hi_run_q;
    int lo_run_q;
    bit seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q <= 0;
            lo_run_q <= 0;
            seen_q   <= 1'b0;
        end else if (pulse_o) begin
            hi_run_q <= hi_run_q + 1;
            lo_run_q <= 0;
            seen_q   <= 1'b1;
        end else begin
            hi_run_q <= 0;
            if (lo_run_q < 1000000) lo_run_q <= lo_run_q + 1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (state_i == PG_IDLE) && !pulse_o)
        else $error("reset left machine in %s", state_name); // R1

    AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
        (state_i == PG_IDLE && trig_i) |=> pulse_o)
        else $error("no pulse after trigger, state %s", state_name); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_i == PG_IDLE && !trig_i) |=> (state_i == PG_IDLE) && !pulse_o)
        else $error("left idle without trigger, state %s", state_name); // R3

    AST_HI_BOUND: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (hi_run_q < HIGH_CYCLES))
        else $error("pulse too long, state %s", state_name); // R4

    AST_HI_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && $past(pulse_o) && !$past(rst)) |-> (hi_run_q == HIGH_CYCLES))
        else $error("pulse too short, state %s", state_name); // R4

    AST_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && !$past(pulse_o) && !$past(rst) && seen_q) |-> (lo_run_q >= HOLD_CYCLES))
        else $error("holdoff too short, state %s", state_name); // R5

    AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (rst)
        (state_i != PG_IDLE) |=> (state_i != PG_HI_LOAD))
        else $error("pulse restarted outside idle, state %s", state_name); // R7

endmodule

bind trig_pulse_gen pg_checker #(
    .HIGH_CYCLES (HIGH_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_pg_chk (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_i),
    .pulse_o (pulse_o),
    .state_i (cur_state)
);

// File: tb/test_trig_pulse_gen.sv
`timescale 1ns/1ps
module test_trig_pulse_gen;
    import pg_pkg::*;

    localparam int HI = 6;
    localparam int LO = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic q_bin, q_oh, q_gray;

    always #2.5 clk = ~clk;

    trig_pulse_gen #(.HIGH_CYCLES(HI), .HOLD_CYCLES(LO),
                     .STATE_ENC(PG_ENC_BINARY), .Q_REGISTERED(1'b0))
        i_trig_pulse_gen (.clk(clk), .rst(rst), .trig_i(trig), .pulse_o(q_bin));

    trig_pulse_gen #(.HIGH_CYCLES(HI), .HOLD_CYCLES(LO),
                     .STATE_ENC(PG_ENC_ONEHOT), .Q_REGISTERED(1'b1))
        i_trig_pulse_gen_oh (.clk(clk), .rst(rst), .trig_i(trig), .pulse_o(q_oh));

    trig_pulse_gen #(.HIGH_CYCLES(HI), .HOLD_CYCLES(LO),
                     .STATE_ENC(PG_ENC_GRAY), .Q_REGISTERED(1'b1))
        i_trig_pulse_gen_gray (.clk(clk), .rst(rst), .trig_i(trig), .pulse_o(q_gray));

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Behavioural reference: remaining high and low cycles
    int m_hi = 0;
    int m_lo = 0;
    bit m_after_rst = 1'b0;

    always @(posedge clk) begin
        cyc++;
        m_after_rst = 1'b0;
        if (rst) begin
            m_hi = 0;
            m_lo = 0;
            m_after_rst = 1'b1;
        end else if (m_hi > 0) begin
            m_hi--;
            if (m_hi == 0) m_lo = LO;
        end else if (m_lo > 0) begin
            m_lo--;
        end else if (trig) begin
            m_hi = HI;
        end
    end

    task automatic check(input logic got, input logic exp, input string tag, input string who);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: got %0b expected %0b", tag, who, cyc, got, exp);
        end
    endtask

    // phase: 0 other, 1 trigger held, 2 trigger toggling
    int phase = 0;
    int rises[$];
    int hrun = 0;
    bit track = 1'b0;
    logic q_prev = 1'b0;

    always @(negedge clk) begin
        if (cyc > 0) begin
            logic exp_q;
            string tag;
            exp_q = (m_hi > 0);
            if (m_after_rst)      tag = "R1";
            else if (m_hi == HI)  tag = "R2";
            else if (m_hi > 0)    tag = "R4";
            else if (m_lo > 0)    tag = "R5";
            else                  tag = "R3";
            check(q_bin,  exp_q, tag, "binary/decoded");
            check(q_oh,   exp_q, {"R8/", tag}, "onehot/registered");
            check(q_gray, exp_q, {"R8/", tag}, "gray/registered");

            if (q_bin && !q_prev) begin
                hrun  = 1;
                track = (phase == 2);
                if (phase == 1) rises.push_back(cyc);
            end else if (q_bin) begin
                hrun++;
            end else if (q_prev && track) begin
                check(hrun == HI, 1'b1, "R7", "pulse length under toggling trigger");
                track = 1'b0;
            end
            q_prev = q_bin;
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got cycle %0d expected < 20000", cyc);
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        rst  = 1'b1;
        trig = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3: idle with trigger low
        repeat (6) @(negedge clk);

        // R2, R4, R5: single-cycle trigger
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (25) @(negedge clk);

        // R6: trigger held high
        phase = 1;
        trig  = 1'b1;
        repeat (60) @(negedge clk);
        trig  = 1'b0;
        phase = 0;
        n_tests++;
        if (rises.size() < 3) begin
            n_fail++;
            $display("FAIL R6 held trigger: got %0d rises expected at least 3", rises.size());
        end
        for (int i = 1; i < rises.size(); i++) begin
            check((rises[i] - rises[i-1]) == (HI + LO + 1), 1'b1, "R6", "rise spacing");
            if ((rises[i] - rises[i-1]) != (HI + LO + 1))
                $display("  spacing got %0d expected %0d", rises[i] - rises[i-1], HI + LO + 1);
        end
        repeat (20) @(negedge clk);

        // R7: trigger toggling every cycle
        phase = 2;
        for (int i = 0; i < 80; i++) begin
            trig = ~trig;
            @(negedge clk);
        end
        trig  = 1'b0;
        phase = 0;
        repeat (20) @(negedge clk);

        // R8 and all phases: pseudo-random trigger
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            trig = lfsr[0] & lfsr[3];
            @(negedge clk);
        end
        trig = 1'b0;
        repeat (20) @(negedge clk);

        // R1: reset in mid-pulse with trigger high
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        trig = 1'b1;
        rst  = 1'b1;
        @(negedge clk);
        rst  = 1'b0;
        repeat (30) @(negedge clk);
        trig = 1'b0;
        repeat (20) @(negedge clk);

        finish_run();
    end

endmodule